// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps the pending state of two interrupt classes for a small group of processors (up to four): inter-processor interrupts raised by software, and periodic timer interrupts raised by a tick pulse from an external timer. Each processor has one pending bit per class, and the block drives that bit straight out as a level interrupt line. The timer line is meant for a lower interrupt level and the inter-processor line for a higher level. The priority between them is resolved inside each processor, not here.

Software reaches the block through a 64-bit register port that also carries the number of the accessing processor. The most compact way in is a packed control word. A single write to it can post inter-processor interrupts, clear inter-processor interrupts and clear timer interrupts, each through its own 4-bit per-processor field. It can also carry a memory-error acknowledge bit that is accepted and otherwise ignored. A control-word write that carries none of these is refused and flagged. Three dedicated registers offer the same operations with a plain mask in the low bits. Posting an interrupt that is already pending, or clearing one that is not, changes nothing and raises a one-cycle warning pulse.

Register word indices: 0 = control word, 1 = inter-processor pending, 2 = timer pending, 3 = inter-processor post. A write to any other index is ignored, and a read of any other index returns zero.

Top module: `ipiTimerCtl`

## Requirements
- R1: Reset clears both pending vectors. All `ipiIrq` and `timerIrq` lines, `rdData`, `warnFlag` and `badWrite` read zero after reset.
- R2: In a control-word write (index 0), each set bit n of wrData[15:12] posts an inter-processor interrupt to processor n. `ipiIrq[n]` is high from the clock edge that takes the write.
- R3: In a control-word write, set bits of wrData[11:8] clear inter-processor pending bits and set bits of wrData[7:4] clear timer pending bits. Bit n of each field acts on processor n. When the same write both posts and clears for one processor, the clear wins.
- R4: wrData[28] of a control-word write is an acknowledge. It makes the write legal but changes no state and raises no flag.
- R5: A control-word write whose bits 15:4 and bit 28 are all zero is unsupported. `badWrite` pulses for one cycle after the write, and no pending bit changes.
- R6: Posting an inter-processor interrupt that is already pending, or clearing one that is neither pending nor posted in the same write, leaves that bit unchanged. `warnFlag` pulses for exactly the cycle after that write.
- R7: A `tickPulse` sets the timer pending bit of every present processor. A timer clear for the same processor in the same cycle loses to the tick.
- R8: A write to index 1 clears the inter-processor pending bits selected by wrData[3:0]. A read of index 1 returns the inter-processor pending vector in bits 3:0.
- R9: A write to index 2 clears the timer pending bits selected by wrData[3:0]. A read of index 2 returns the timer pending vector in bits 3:0.
- R10: A write to index 3 posts inter-processor interrupts to the processors selected by wrData[3:0], and flags redundant posts as in R6.
- R11: A read of index 0 returns the accessing processor number in bits 1:0, the timer pending vector in bits 7:4 and the inter-processor pending vector in bits 11:8, with all other bits zero. `rdData` is valid from the edge that takes `rdEn`.
- R12: Only processors 0 to NUM_CPU-1 are present. Mask bits for absent processors have no effect, raise no warning, and their interrupt lines stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word index |
| wrData | input | 64 | Write data |
| accessCpu | input | 2 | Number of the accessing processor |
| tickPulse | input | 1 | One-cycle timer tick |
| rdData | output | 64 | Registered read data |
| timerIrq | output | 4 | Timer interrupt level per processor |
| ipiIrq | output | 4 | Inter-processor interrupt level per processor |
| warnFlag | output | 1 | Pulse on a redundant post or clear |
| badWrite | output | 1 | Pulse on an unsupported control-word write |

## Verification
Every result of this block lands on the first clock edge after its stimulus. Pending bits and interrupt lines change at the edge that takes a write or a tick. `warnFlag` and `badWrite` are high only from that edge to the next. `rdData` holds the value selected at the edge that took `rdEn`. The bench drives each access on a falling edge, removes it on the next falling edge and samples at that moment, so each check sees exactly one rising edge after its stimulus. The check also falls before the following edge, which could otherwise clear a pulse. The inter-processor sweep covers every start state, post field and clear field. The timer sweeps cover every clear mask, both alone and against a simultaneous tick.

// File: rtl/ipiTimerPkg.sv
package ipiTimerPkg;
  localparam int FIELD_W    = 4;
  localparam int DATA_W     = 64;
  localparam int CPU_ID_W   = 2;
  localparam int POST_LSB   = 12;
  localparam int IPICLR_LSB = 8;
  localparam int TMRCLR_LSB = 4;
  localparam int ACK_BIT    = 28;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_IPI    = 1;
  localparam int IDX_TMR    = 2;
  localparam int IDX_POST   = 3;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_CTRL = 3'd1,
    RD_IPI  = 3'd2,
    RD_TMR  = 3'd3
  } rdSelE;

  typedef struct packed {
    logic [FIELD_W-1:0] ipiSet;
    logic [FIELD_W-1:0] ipiClr;
    logic [FIELD_W-1:0] tmrClr;
    logic               tick;
    logic               badWrite;
    logic               rdStrobe;
    rdSelE              rdSel;
  } strobeT;
endpackage

// File: rtl/ipiTimerDecode.sv
module ipiTimerDecode
  import ipiTimerPkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickPulse,
  output strobeT            strb
);
  localparam logic [FIELD_W-1:0] PRESENT = FIELD_W'((1 << NUM_CPU) - 1);

  logic wrCtrl, wrIpi, wrTmr, wrPost;
  logic [FIELD_W-1:0] postField, ipiClrField, tmrClrField, lowMask;
  logic ackBit, anyField;

  always_comb begin
    wrCtrl = wrEn && (regAddr == ADDR_W'(IDX_CTRL));
    wrIpi  = wrEn && (regAddr == ADDR_W'(IDX_IPI));
    wrTmr  = wrEn && (regAddr == ADDR_W'(IDX_TMR));
    wrPost = wrEn && (regAddr == ADDR_W'(IDX_POST));

    postField   = wrData[POST_LSB   +: FIELD_W];
    ipiClrField = wrData[IPICLR_LSB +: FIELD_W];
    tmrClrField = wrData[TMRCLR_LSB +: FIELD_W];
    lowMask     = wrData[FIELD_W-1:0];
    ackBit      = wrData[ACK_BIT];
    anyField    = (|postField) || (|ipiClrField) || (|tmrClrField) || ackBit;
  end

  always_comb begin
    strb = '0;
    strb.tick = tickPulse;
    if (wrCtrl && anyField) begin
      strb.ipiSet = postField & PRESENT;
      strb.ipiClr = ipiClrField & PRESENT;
      strb.tmrClr = tmrClrField & PRESENT;
    end
    if (wrCtrl && !anyField) strb.badWrite = 1'b1;
    if (wrIpi)  strb.ipiClr = lowMask & PRESENT;
    if (wrTmr)  strb.tmrClr = lowMask & PRESENT;
    if (wrPost) strb.ipiSet = lowMask & PRESENT;

    strb.rdStrobe = rdEn;
    if (regAddr == ADDR_W'(IDX_CTRL))     strb.rdSel = RD_CTRL;
    else if (regAddr == ADDR_W'(IDX_IPI)) strb.rdSel = RD_IPI;
    else if (regAddr == ADDR_W'(IDX_TMR)) strb.rdSel = RD_TMR;
    else                                  strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/ipiTimerState.sv
module ipiTimerState
  import ipiTimerPkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [CPU_ID_W-1:0] accessCpu,
  output logic [FIELD_W-1:0]  ipiPend,
  output logic [FIELD_W-1:0]  tmrPend,
  output logic [DATA_W-1:0]   rdData,
  output logic                warnFlag,
  output logic                badFlag
);
  localparam logic [FIELD_W-1:0] PRESENT = FIELD_W'((1 << NUM_CPU) - 1);

  logic [FIELD_W-1:0] redundantBit;

  for (genvar g = 0; g < FIELD_W; g++) begin : gCpu
    if (g < NUM_CPU) begin : gLive
      logic ipiQ, tmrQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ipiQ <= 1'b0;
          tmrQ <= 1'b0;
        end else begin
          ipiQ <= (ipiQ | strb.ipiSet[g]) & ~strb.ipiClr[g];
          tmrQ <= (tmrQ & ~strb.tmrClr[g]) | strb.tick;
        end
      end
      assign ipiPend[g] = ipiQ;
      assign tmrPend[g] = tmrQ;
      assign redundantBit[g] = (strb.ipiSet[g] & ipiQ) |
                               (strb.ipiClr[g] & ~ipiQ & ~strb.ipiSet[g]);
    end else begin : gAbsent
      assign ipiPend[g] = 1'b0;
      assign tmrPend[g] = 1'b0;
      assign redundantBit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnFlag <= 1'b0;
      badFlag  <= 1'b0;
      rdData   <= '0;
    end else begin
      warnFlag <= |redundantBit;
      badFlag  <= strb.badWrite;
      if (strb.rdStrobe) begin
        rdData <= '0;
        unique case (strb.rdSel)
          RD_CTRL: begin
            rdData[CPU_ID_W-1:0]          <= accessCpu;
            rdData[TMRCLR_LSB +: FIELD_W] <= tmrPend;
            rdData[IPICLR_LSB +: FIELD_W] <= ipiPend;
          end
          RD_IPI:  rdData[FIELD_W-1:0] <= ipiPend;
          RD_TMR:  rdData[FIELD_W-1:0] <= tmrPend;
          default: rdData <= '0;
        endcase
      end
    end
  end

  // R7: a tick leaves every present timer bit pending
  assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> ((tmrPend & PRESENT) == PRESENT));

  // R12: absent processors never show pending state
  assert_absent_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((ipiPend | tmrPend) & ~PRESENT) == '0);

  // R5: an unsupported write leaves the inter-processor state alone
  assert_bad_no_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.badWrite |=> $stable(ipiPend));

  // R3: a requested clear always takes effect
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.ipiClr) |=> ((ipiPend & $past(strb.ipiClr)) == '0));

  // R6: a warning pulse follows only a write that touched the vector
  assert_warn_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnFlag) |-> $past(|(strb.ipiSet | strb.ipiClr)));
endmodule

// File: rtl/ipiTimerCtl.sv
module ipiTimerCtl
  import ipiTimerPkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [63:0]       wrData,
  input  logic [1:0]        accessCpu,
  input  logic              tickPulse,
  output logic [63:0]       rdData,
  output logic [3:0]        timerIrq,
  output logic [3:0]        ipiIrq,
  output logic              warnFlag,
  output logic              badWrite
);
  strobeT strb;

  ipiTimerDecode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) i_decode (
    .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr), .wrData(wrData),
    .tickPulse(tickPulse), .strb(strb)
  );

  ipiTimerState #(.NUM_CPU(NUM_CPU)) i_state (
    .clk(clk), .rstN(rstN), .strb(strb), .accessCpu(accessCpu),
    .ipiPend(ipiIrq), .tmrPend(timerIrq), .rdData(rdData),
    .warnFlag(warnFlag), .badFlag(badWrite)
  );
endmodule

// File: tb/test_ipiTimerCtl.sv
module test_ipiTimerCtl;
  localparam int NCPU = 3;
  localparam logic [3:0] PM = 4'b0111;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, tickPulse = 0;
  logic [3:0] regAddr = 0;
  logic [63:0] wrData = 0;
  logic [1:0] accessCpu = 0;
  logic [63:0] rdData;
  logic [3:0] timerIrq, ipiIrq;
  logic warnFlag, badWrite;
  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipiTimerCtl #(.NUM_CPU(NCPU), .ADDR_W(4)) i_ipiTimerCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .accessCpu(accessCpu), .tickPulse(tickPulse),
    .rdData(rdData), .timerIrq(timerIrq), .ipiIrq(ipiIrq),
    .warnFlag(warnFlag), .badWrite(badWrite)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d, bit tk = 0);
    @(negedge clk);
    wrEn = 1; regAddr = a; wrData = d; tickPulse = tk;
    @(negedge clk);
    wrEn = 0; tickPulse = 0; wrData = 0;
  endtask

  task automatic tick();
    @(negedge clk); tickPulse = 1;
    @(negedge clk); tickPulse = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] cpu);
    @(negedge clk);
    rdEn = 1; regAddr = a; accessCpu = cpu;
    @(negedge clk);
    rdEn = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog got=%0d exp<150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 ipiIrq", {60'd0, ipiIrq}, 0);
    check("R1 timerIrq", {60'd0, timerIrq}, 0);
    check("R1 rdData", rdData, 0);
    check("R1 flags", {62'd0, warnFlag, badWrite}, 0);

    // R2 R3 R5 R6 R12: exhaustive control-word sweep
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 16; c++) begin
          logic [3:0] sp, rp, cp, expV;
          logic expW, expB;
          sp = 4'(s) & PM; rp = 4'(r) & PM; cp = 4'(c) & PM;
          wr(4'd1, 64'hF);
          if (sp != 0) wr(4'd3, {60'd0, 4'(s)});
          wr(4'd0, {48'd0, 4'(r), 4'(c), 8'd0});
          expB = (r == 0 && c == 0);
          expV = expB ? sp : ((sp | rp) & ~cp);
          expW = !expB && ((|(rp & sp)) || (|(cp & ~(sp | rp))));
          check("R2/R3/R12 ipiIrq", {60'd0, ipiIrq}, {60'd0, expV});
          check("R6 warnFlag", {63'd0, warnFlag}, {63'd0, expW});
          check("R5 badWrite", {63'd0, badWrite}, {63'd0, expB});
        end

    // R4 acknowledge bit alone: legal, no effect
    wr(4'd1, 64'hF);
    wr(4'd3, 64'h5);
    wr(4'd0, 64'h1000_0000);
    check("R4 ipiIrq", {60'd0, ipiIrq}, 64'h5);
    check("R4 badWrite", {63'd0, badWrite}, 0);
    check("R4 warnFlag", {63'd0, warnFlag}, 0);
    // R5 bits outside all fields only
    wr(4'd0, 64'hFFFF_0000_0000_000F);
    check("R5 high bits badWrite", {63'd0, badWrite}, 1);
    check("R5 high bits ipiIrq", {60'd0, ipiIrq}, 64'h5);

    // R7 R9 timer: tick, then each clear mask by control word and by register
    for (int c = 0; c < 16; c++) begin
      tick();
      check("R7 tick", {60'd0, timerIrq}, {60'd0, PM});
      wr(4'd0, {56'd0, 4'(c), 4'd0} | (c == 0 ? 64'h1000_0000 : 64'd0));
      check("R3 timer clear", {60'd0, timerIrq}, {60'd0, PM & ~4'(c)});
      tick();
      wr(4'd2, {60'd0, 4'(c)});
      check("R9 timer reg clear", {60'd0, timerIrq}, {60'd0, PM & ~4'(c)});
      rd(4'd2, 0);
      check("R9 timer read", rdData, {60'd0, PM & ~4'(c)});
      wr(4'd2, {60'd0, 4'(c)}, 1);
      check("R7 tick beats clear", {60'd0, timerIrq}, {60'd0, PM});
    end

    // R8 R10 dedicated inter-processor registers
    for (int m = 0; m < 16; m++) begin
      wr(4'd1, 64'hF);
      wr(4'd3, {60'd0, 4'(m)});
      check("R10 post reg", {60'd0, ipiIrq}, {60'd0, 4'(m) & PM});
      wr(4'd3, {60'd0, 4'(m)});
      check("R10 redundant warn", {63'd0, warnFlag}, {63'd0, |(4'(m) & PM)});
      rd(4'd1, 0);
      check("R8 ipi read", rdData, {60'd0, 4'(m) & PM});
      wr(4'd1, 64'h5);
      check("R8 ipi reg clear", {60'd0, ipiIrq}, {60'd0, 4'(m) & PM & 4'b1010});
    end

    // R11 control-word read with each processor number
    wr(4'd1, 64'hF);
    wr(4'd3, 64'h2);
    wr(4'd2, 64'hF);
    tick();
    wr(4'd2, 64'h4);
    for (int k = 0; k < 4; k++) begin
      rd(4'd0, 2'(k));
      check("R11 ctrl read", rdData, 64'h0000_0000_0000_0230 | 64'(k));
    end
    rd(4'd9, 2'd1);
    check("R11 unmapped read", rdData, 0);

    // R1 again: reset mid-run
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    check("R1 reset ipi", {60'd0, ipiIrq}, 0);
    check("R1 reset timer", {60'd0, timerIrq}, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule